// File: doc/BRIEF.md
# Digit-Serial Adder

This block adds two operands that arrive one digit per clock, least significant digit first. A digit holds DIG_W bits, and a word holds WORD_W bits, where WORD_W is a whole multiple of DIG_W. Setting DIG_W to 1 turns the block into a plain bit-serial adder. Each clock adds one operand digit from each side with a chain of DIG_W full-adder slices. The carry ripples through the slices inside the cycle, and the carry out of the top slice goes into a register that feeds the next digit.

A strobe marks the first digit of every word. On that digit the incoming carry is forced to zero, so words can follow one another with no gap and never share a carry. The sum digit is registered and appears one clock after its operand digit. On the last digit of a word, the carry out of the top slice is presented as an overflow flag for that word and is then discarded.

Top module: `dser_add`

## Requirements
- R1: After reset (rst_ni low), the outputs are `sum_o`=0, `sum_vld_o`=0 and `ovf_vld_o`=0.
- R2: Each digit with `vld_i` high produces a sum digit on `sum_o`, with `sum_vld_o` high, exactly one clock later. Bit 0 of a digit is the less significant bit.
- R3: Within a digit, the carry ripples through all DIG_W bit slices in the same cycle. The sum digit equals (a + b + carry_in) mod 2^DIG_W.
- R4: The carry out of digit k is the carry into digit k+1 of the same word.
- R5: On a digit with `sof_i` high, the carry in is zero, whatever the previous word left behind.
- R6: The WORD_W/DIG_W sum digits of a word, put back together least significant digit first, equal (A+B) mod 2^WORD_W.
- R7: One clock after the last digit of a word, `ovf_vld_o` is high and `ovf_o` equals bit WORD_W of A+B. `ovf_vld_o` is low on every other cycle.
- R8: A clock with `vld_i` low changes neither the carry nor the digit position. `sum_vld_o` and `ovf_vld_o` are low in the next cycle, and the word resumes correctly at the next valid digit.
- R9: Words may follow back to back, with no idle cycle between them.
- R10: Elaboration stops if WORD_W is not a multiple of DIG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operand digit valid |
| sof_i | input | 1 | First digit of a word |
| a_i | input | DIG_W | Operand A digit |
| b_i | input | DIG_W | Operand B digit |
| sum_o | output | DIG_W | Registered sum digit |
| sum_vld_o | output | 1 | Sum digit valid |
| ovf_o | output | 1 | Carry out of the word |
| ovf_vld_o | output | 1 | Overflow valid, on the last digit of a word |

## Verification
All-ones operands plus one make the carry travel through every slice and across every digit boundary. This separates a correct ripple from a broken slice chain or a lost digit carry. A word that overflows followed at once by zero operands shows whether the carry is cleared at the word start. Random back-to-back words, some with idle gaps inside them, compare each reassembled sum and overflow flag against a full-width addition. This exposes errors in gap handling and in tracking the digit position.

// File: rtl/dser_add_pkg.sv
package dser_add_pkg;
  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/dser_digit_add.sv
module dser_digit_add #(
  parameter int unsigned DIG_W = 2
) (
  input  logic [DIG_W-1:0] a_i,
  input  logic [DIG_W-1:0] b_i,
  input  logic             cin_i,
  output logic [DIG_W-1:0] s_o,
  output logic             cout_o
);
  logic [DIG_W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < DIG_W; i++) begin : g_fa
    assign s_o[i]   = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[DIG_W];
endmodule

// File: rtl/dser_seq.sv
module dser_seq #(
  parameter int unsigned NDIG = 2,
  parameter int unsigned CW   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic sof_i,
  output logic last_o
);
  logic [CW-1:0] pos_q, pos_cur;

  assign pos_cur = sof_i ? '0 : pos_q;
  assign last_o  = (pos_cur == CW'(NDIG - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (vld_i)  pos_q <= last_o ? '0 : pos_cur + CW'(1);
  end

  // R8: idle clocks leave the digit position alone
  p_pos_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(pos_q));
endmodule

// File: rtl/dser_add.sv
module dser_add
  import dser_add_pkg::*;
#(
  parameter int unsigned WORD_W = 4,
  parameter int unsigned DIG_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic [DIG_W-1:0] a_i,
  input  logic [DIG_W-1:0] b_i,
  output logic [DIG_W-1:0] sum_o,
  output logic             sum_vld_o,
  output logic             ovf_o,
  output logic             ovf_vld_o
);
  localparam int unsigned NDIG = WORD_W / DIG_W;
  localparam int unsigned CW   = clog2_min1(NDIG);

  // R10
  if ((WORD_W % DIG_W) != 0 || DIG_W == 0) begin : g_bad_cfg
    $error("dser_add: WORD_W must be a multiple of DIG_W");
  end

  logic             cy_q, cin, cout, last;
  logic [DIG_W-1:0] s;

  assign cin = sof_i ? 1'b0 : cy_q;

  dser_digit_add #(.DIG_W(DIG_W)) u_dig (
    .a_i(a_i), .b_i(b_i), .cin_i(cin), .s_o(s), .cout_o(cout)
  );

  dser_seq #(.NDIG(NDIG), .CW(CW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .sof_i(sof_i), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cy_q      <= 1'b0;
      sum_o     <= '0;
      sum_vld_o <= 1'b0;
      ovf_o     <= 1'b0;
      ovf_vld_o <= 1'b0;
    end else begin
      sum_vld_o <= vld_i;
      ovf_vld_o <= vld_i & last;
      if (vld_i) begin
        sum_o <= s;
        cy_q  <= last ? 1'b0 : cout;
        ovf_o <= last & cout;
      end
    end
  end

  // R2: one sum digit per valid input digit, one clock later
  p_sum_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> sum_vld_o);
  p_sum_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !sum_vld_o && !ovf_vld_o);
  // R7: overflow only with a sum digit
  p_ovf_with_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_vld_o |-> sum_vld_o);
  // R8: carry held over idle clocks
  p_cy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(cy_q));
  // R5: a first digit of zeros gives a zero sum digit
  p_sof_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sof_i && a_i == '0 && b_i == '0) |=> sum_o == '0);
  // R7: the carry register is empty after a word ends
  p_cy_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_vld_o |-> !cy_q);
endmodule

// File: tb/sim_dser_add.sv
module sim_dser_add;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned DIG_W  = 2;
  localparam int unsigned NDIG   = WORD_W / DIG_W;

  logic clk_i = 1'b0, rst_ni = 1'b0, vld_i = 1'b0, sof_i = 1'b0;
  logic [DIG_W-1:0] a_i = '0, b_i = '0, sum_o;
  logic sum_vld_o, ovf_o, ovf_vld_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dser_add #(.WORD_W(WORD_W), .DIG_W(DIG_W)) u0 (.*);

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W:0] ref_add(input logic [WORD_W-1:0] a, b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Drives one word (optionally with idle gaps) and checks sum digits and overflow.
  task automatic do_word(input logic [WORD_W-1:0] a, b, input bit gaps, input string req);
    logic [WORD_W:0] exp;
    logic [WORD_W-1:0] got;
    exp = ref_add(a, b);
    got = '0;
    for (int d = 0; d < NDIG; d++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk_i); vld_i = 1'b0; sof_i = 1'b0;
        @(negedge clk_i);
        check({req, "/R8 idle"}, {sum_vld_o, ovf_vld_o}, 0);
      end else if (d > 0 || !gaps) begin
        @(negedge clk_i);
      end else begin
        @(negedge clk_i);
      end
      vld_i = 1'b1; sof_i = (d == 0);
      a_i = a[d*DIG_W +: DIG_W]; b_i = b[d*DIG_W +: DIG_W];
      @(posedge clk_i); #1;
      check({req, "/R2 sum_vld"}, sum_vld_o, 1);
      got[d*DIG_W +: DIG_W] = sum_o;
      if (d == NDIG-1) begin
        check({req, "/R7 ovf_vld"}, ovf_vld_o, 1);
        check({req, "/R7 ovf"}, ovf_o, exp[WORD_W]);
      end else begin
        check({req, "/R7 no ovf_vld"}, ovf_vld_o, 0);
      end
    end
    check({req, "/R6 word sum"}, got, exp[WORD_W-1:0]);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 sum", sum_o, 0);
    check("R1 sum_vld", sum_vld_o, 0);
    check("R1 ovf_vld", ovf_vld_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    do_word(4'hF, 4'h1, 0, "R3 R4 full ripple");
    do_word(4'h0, 4'h0, 0, "R5 carry cleared");
    do_word(4'h3, 4'h1, 0, "R4 digit carry");
    do_word(4'hF, 4'hF, 0, "R9 back to back");
    do_word(4'h8, 4'h8, 0, "R7 overflow");
    do_word(4'h0, 4'h0, 0, "R5 after ovf");
    for (int i = 0; i < 300; i++)
      do_word(WORD_W'($urandom), WORD_W'($urandom), ($urandom % 2) == 1, "R6 random");
    @(negedge clk_i); vld_i = 1'b0; sof_i = 1'b0;
    @(negedge clk_i);
    check("R8 idle end", {sum_vld_o, ovf_vld_o}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule